// File: doc/BRIEF.md
# Power Line Command Transmit Sequencer

This block sends one home-automation command over a carrier-current modem that sits on the AC mains. A command carries a 4-bit house code, a 5-bit key code and a repeat count, and it is handed over with a valid/ready handshake. The sequencer watches a zero-crossing signal from the modem. It drives a carrier-enable output, and every mains half cycle carries one slot of the frame. A slot holding a one gets a carrier burst of fixed length that starts right after the crossing. A slot holding a zero gets no burst.

A frame has 22 slots. The first four form a fixed start pattern. Eight slots carry the house code and ten slots carry the key code, and each code bit is sent first as itself and then inverted. Before the first frame the block lets six crossings of silence pass. The frame is then sent as many times as requested, with no gap between copies. The block times every interval between crossings. An interval that is too short or too long ends the command at once and reports a framing fault. If no crossing arrives at all, the block reports a sync fault. Every time value is given in microseconds and converted to clock cycles from the clock-frequency parameter, so one build works on 50 Hz or 60 Hz mains.

Top module: `plc_tx_sequencer`

## Requirements
- R1: A request whose house code is 16 or more, or whose key code is 32 or more, is answered one cycle after acceptance with `done_o` high and `status_o` = 1 (rejected), and no carrier is driven.
- R2: `req_ready_o` is high only while the block is idle, and the carrier is never on while it is high.
- R3: If no zero-crossing edge arrives within the timeout (TIMEOUT_US converted to cycles) after acceptance, `done_o` rises with `status_o` = 2 (no sync) exactly timeout+1 cycles after the accepting edge, and no carrier is driven.
- R4: No carrier is driven on the first crossing after acceptance, nor during the next six crossings of silence. The sixth silent crossing opens slot 0.
- R5: Slots 0 to 3 carry 1,1,1,0. In each slot pair that follows, the even slot carries the bit and the odd slot carries its inverse.
- R6: Slots 4 to 11 carry the house line nibble, most significant bit first. The nibbles for house codes 0 to 15 are 6, 14, 2, 10, 1, 9, 5, 13, 7, 15, 3, 11, 0, 8, 4, 12.
- R7: Slots 12 to 21 carry a 5-bit key line code, most significant bit first. For a key k below 16 the code is the house nibble of k followed by 0. For a key k of 16 or more the code is 2*(k-16)+1.
- R8: A one slot drives the carrier for exactly PULSE_US worth of cycles. The carrier is first seen high on the third clock edge after the zero-crossing input changes (two synchroniser flops and one output register).
- R9: With a repeat count n of 1 or more, n frames of 22 slots follow each other with no gap. `done_o` rises with `status_o` = 0 on the crossing that closes the last slot.
- R10: A valid request with a repeat count of 0 completes one cycle after acceptance with `status_o` = 0, without waiting for any crossing and without carrier.
- R11: A crossing that arrives earlier than MIN_IVL_US after the previous one raises `done_o` with `status_o` = 3 (framing). The carrier is dropped in the same cycle, even in the middle of a burst. An interval of exactly MIN_IVL_US is accepted.
- R12: When no crossing follows within MAX_IVL_US, `done_o` rises with `status_o` = 3 one cycle after the limit has been exceeded. An interval of exactly MAX_IVL_US is accepted.
- R13: `done_o` is a single-cycle pulse, and after it the block is idle and ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| zc_i | input | 1 | Raw zero-crossing level from the modem; both edges count |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request taken when valid is high |
| req_house_i | input | 5 | House code, 0..15 legal |
| req_key_i | input | 6 | Key code, 0..31 legal |
| req_reps_i | input | REP_W | Number of back-to-back frames |
| carrier_o | output | 1 | Carrier enable to the modem |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Result with done: 0 ok, 1 rejected, 2 no sync, 3 framing |

## Verification
Some properties are checked on every cycle. The carrier stays quiet while the block is idle or waiting out the silence. A burst ends only at its full length or through an abort. A framing fault never leaves the carrier on. Completion is a single pulse, and a rejected request is answered on the next cycle. Other behaviour shows only in the bench scenarios: that slot contents follow the house and key line codes, the exact cycle at which timeouts fire, and the acceptance of intervals exactly at the limits. The bench covers these by sweeping all 32 key codes across all 16 house codes and measuring the carrier in every half cycle.

// File: rtl/plc_pkg.sv
package plc_pkg;

    localparam int SLOTS     = 22;
    localparam int GAP_EDGES = 6;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int GAP_W     = $clog2(GAP_EDGES);

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_REJECT  = 2'd1,
        ST_NOSYNC  = 2'd2,
        ST_FRAMING = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SYNC = 2'd1,
        PH_GAP  = 2'd2,
        PH_SEND = 2'd3
    } phase_e;

    // line nibble for a 4-bit house (or low unit) code
    function automatic logic [3:0] line_nibble(input logic [3:0] code);
        logic [3:0] n;
        unique case (code)
            4'd0:  n = 4'd6;
            4'd1:  n = 4'd14;
            4'd2:  n = 4'd2;
            4'd3:  n = 4'd10;
            4'd4:  n = 4'd1;
            4'd5:  n = 4'd9;
            4'd6:  n = 4'd5;
            4'd7:  n = 4'd13;
            4'd8:  n = 4'd7;
            4'd9:  n = 4'd15;
            4'd10: n = 4'd3;
            4'd11: n = 4'd11;
            4'd12: n = 4'd0;
            4'd13: n = 4'd8;
            4'd14: n = 4'd4;
            default: n = 4'd12;
        endcase
        return n;
    endfunction

    function automatic logic [4:0] key_line(input logic [4:0] key);
        if (key[4]) return {key[3:0], 1'b1};
        return {line_nibble(key[3:0]), 1'b0};
    endfunction

    // bit s of the result is the content of slot s
    function automatic logic [SLOTS-1:0] build_frame(input logic [3:0] house,
                                                     input logic [4:0] key);
        logic [SLOTS-1:0] f;
        logic [3:0] h;
        logic [4:0] k;
        h = line_nibble(house);
        k = key_line(key);
        f[3:0] = 4'b0111;
        for (int i = 0; i < 4; i++) begin
            f[4 + 2*i] = h[3-i];
            f[5 + 2*i] = ~h[3-i];
        end
        for (int i = 0; i < 5; i++) begin
            f[12 + 2*i] = k[4-i];
            f[13 + 2*i] = ~k[4-i];
        end
        return f;
    endfunction

endpackage

// File: rtl/plc_zc_sync.sv
module plc_zc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic zc_i,
    output logic edge_o
);

    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], zc_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign edge_o = sh_q[STAGES-1] ^ sh_q[STAGES];

endmodule

// File: rtl/plc_ivl_timer.sv
module plc_ivl_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)          cnt_d = '0;
        else if (cnt_q != '1)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/plc_pulse_gen.sv
module plc_pulse_gen #(
    parameter int unsigned PULSE_CYC = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    input  logic bit_i,
    input  logic abort_i,
    output logic carrier_o
);

    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

    typedef struct packed {
        logic          on;
        logic [PW-1:0] cnt;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (abort_i) begin
            pg_d.on = 1'b0;
        end else if (fire_i) begin
            pg_d.on  = bit_i;
            pg_d.cnt = '0;
        end else if (pg_q.on) begin
            if (pg_q.cnt == LAST) pg_d.on  = 1'b0;
            else                  pg_d.cnt = pg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pg_q <= '0;
        else         pg_q <= pg_d;
    end

    assign carrier_o = pg_q.on;

    AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(carrier_o) |-> ($past(pg_q.cnt) == LAST || $past(abort_i))); // R8

    AST_ZERO_SLOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_i && !bit_i && !abort_i) |=> !carrier_o); // R5

endmodule

// File: rtl/plc_tx_sequencer.sv
module plc_tx_sequencer
    import plc_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned PULSE_US   = 1000,
    parameter int unsigned MIN_IVL_US = 6000,
    parameter int unsigned MAX_IVL_US = 8500,
    parameter int unsigned TIMEOUT_US = 250_000,
    parameter int unsigned REP_W      = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             zc_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [4:0]       req_house_i,
    input  logic [5:0]       req_key_i,
    input  logic [REP_W-1:0] req_reps_i,
    output logic             carrier_o,
    output logic             done_o,
    output logic [1:0]       status_o
);

    localparam longint unsigned PULSE_CYC = (64'(CLK_HZ) * PULSE_US)   / 1_000_000;
    localparam longint unsigned MIN_CYC   = (64'(CLK_HZ) * MIN_IVL_US) / 1_000_000;
    localparam longint unsigned MAX_CYC   = (64'(CLK_HZ) * MAX_IVL_US) / 1_000_000;
    localparam longint unsigned TMO_CYC   = (64'(CLK_HZ) * TIMEOUT_US) / 1_000_000;
    localparam int CNT_W = $clog2((TMO_CYC > MAX_CYC ? TMO_CYC : MAX_CYC) + 1);
    localparam logic [CNT_W-1:0] TMO_C  = CNT_W'(TMO_CYC);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_CYC);
    localparam logic [CNT_W-1:0] MIN_M1 = CNT_W'(MIN_CYC - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [GAP_W-1:0]  LAST_GAP  = GAP_W'(GAP_EDGES - 1);

    typedef struct packed {
        phase_e            ph;
        logic [GAP_W-1:0]  gap;
        logic [SLOT_W-1:0] slot;
        logic [REP_W-1:0]  reps;
        logic [SLOTS-1:0]  frame;
        logic              done;
        status_e           st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             zc_edge;
    logic [CNT_W-1:0] ivl_q;
    logic             restart, fire, fire_bit, abort, bad_ivl;
    logic [SLOT_W-1:0] nxt_slot;

    plc_zc_sync #(.STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .zc_i   (zc_i),
        .edge_o (zc_edge)
    );

    plc_ivl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .cnt_o     (ivl_q)
    );

    plc_pulse_gen #(.PULSE_CYC(32'(PULSE_CYC))) u_pulse (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fire_i    (fire),
        .bit_i     (fire_bit),
        .abort_i   (abort),
        .carrier_o (carrier_o)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        fire     = 1'b0;
        fire_bit = 1'b0;
        abort    = 1'b0;
        restart  = zc_edge;
        bad_ivl  = (ivl_q >= MAX_C) || (zc_edge && (ivl_q < MIN_M1));
        nxt_slot = ctl_q.slot + 1'b1;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid_i) begin
                    if (req_house_i >= 5'd16 || req_key_i >= 6'd32) begin
                        ctl_d.done = 1'b1;
                        ctl_d.st   = ST_REJECT;
                    end else if (req_reps_i == '0) begin
                        ctl_d.done = 1'b1;
                        ctl_d.st   = ST_OK;
                    end else begin
                        ctl_d.ph    = PH_SYNC;
                        ctl_d.reps  = req_reps_i;
                        ctl_d.frame = build_frame(req_house_i[3:0], req_key_i[4:0]);
                        restart     = 1'b1;
                    end
                end
            end
            PH_SYNC: begin
                if (zc_edge) begin
                    ctl_d.ph  = PH_GAP;
                    ctl_d.gap = '0;
                end else if (ivl_q >= TMO_C) begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_NOSYNC;
                end
            end
            PH_GAP: begin
                if (bad_ivl) begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_FRAMING;
                end else if (zc_edge) begin
                    if (ctl_q.gap == LAST_GAP) begin
                        ctl_d.ph   = PH_SEND;
                        ctl_d.slot = '0;
                        fire       = 1'b1;
                        fire_bit   = ctl_q.frame[0];
                    end else begin
                        ctl_d.gap = ctl_q.gap + 1'b1;
                    end
                end
            end
            PH_SEND: begin
                if (bad_ivl) begin
                    abort      = 1'b1;
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_FRAMING;
                end else if (zc_edge) begin
                    if (ctl_q.slot == LAST_SLOT) begin
                        if (ctl_q.reps == REP_W'(1)) begin
                            ctl_d.ph   = PH_IDLE;
                            ctl_d.done = 1'b1;
                            ctl_d.st   = ST_OK;
                        end else begin
                            ctl_d.reps = ctl_q.reps - 1'b1;
                            ctl_d.slot = '0;
                            fire       = 1'b1;
                            fire_bit   = ctl_q.frame[0];
                        end
                    end else begin
                        ctl_d.slot = nxt_slot;
                        fire       = 1'b1;
                        fire_bit   = ctl_q.frame[nxt_slot];
                    end
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign req_ready_o = (ctl_q.ph == PH_IDLE);
    assign done_o      = ctl_q.done;
    assign status_o    = ctl_q.st;

    AST_REJECT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && (req_house_i >= 5'd16 || req_key_i >= 6'd32))
        |=> (done_o && status_o == ST_REJECT)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> !carrier_o); // R2

    AST_NOSYNC_FROM_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && status_o == ST_NOSYNC) |-> $past(ctl_q.ph == PH_SYNC)); // R3

    AST_SILENCE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.ph == PH_SYNC || ctl_q.ph == PH_GAP) |-> !carrier_o); // R4

    AST_FRAMING_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && status_o == ST_FRAMING) |-> !carrier_o); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R13

endmodule

// File: tb/test_plc_tx_sequencer.sv
`timescale 1ns/1ps
module test_plc_tx_sequencer;

    localparam int PULSE = 10;
    localparam int TMOC  = 2500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic zc = 1'b0;
    logic valid = 1'b0;
    logic [4:0] house = '0;
    logic [5:0] key = '0;
    logic [7:0] reps = '0;
    logic ready, carrier, done;
    logic [1:0] status;

    int checks = 0;
    int errors = 0;
    int hnib[16] = '{6, 14, 2, 10, 1, 9, 5, 13, 7, 15, 3, 11, 0, 8, 4, 12};

    always #4 clk = ~clk;

    plc_tx_sequencer #(
        .CLK_HZ(10_000), .PULSE_US(1000), .MIN_IVL_US(6000),
        .MAX_IVL_US(8500), .TIMEOUT_US(250_000), .REP_W(8)
    ) i_plc_tx_sequencer (
        .clk_i(clk), .rst_ni(rst_n), .zc_i(zc),
        .req_valid_i(valid), .req_ready_o(ready),
        .req_house_i(house), .req_key_i(key), .req_reps_i(reps),
        .carrier_o(carrier), .done_o(done), .status_o(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_bit(input int slot, input int h, input int k);
        int kc, i, b;
        if (slot < 4) return (slot == 3) ? 0 : 1;
        if (slot < 12) begin
            i = (slot - 4) / 2;
            b = (hnib[h] >> (3 - i)) & 1;
        end else begin
            kc = (k >= 16) ? 2 * (k - 16) + 1 : 2 * hnib[k];
            i = (slot - 12) / 2;
            b = (kc >> (4 - i)) & 1;
        end
        return (slot % 2 == 0) ? b : 1 - b;
    endfunction

    task automatic issue(input int h, input int k, input int r);
        @(negedge clk);
        house = 5'(h); key = 6'(k); reps = 8'(r); valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic run_cmd(input int h, input int k, input int r, input int hc);
        int last;
        issue(h, k, r);
        chk(ready == 1'b0, "R2", int'(ready), 0);
        repeat (4) @(negedge clk);
        last = 6 + 22 * r;
        for (int w = 0; w <= last; w++) begin
            int hi, dn, st, first, e, s;
            hi = 0; dn = 0; st = 0; first = 0;
            zc = ~zc;
            for (int j = 1; j <= hc; j++) begin
                @(negedge clk);
                if (carrier) begin
                    hi++;
                    if (first == 0) first = j;
                end
                if (done) begin dn++; st = int'(status); end
            end
            if (w < 6) begin
                chk(hi == 0, "R4", hi, 0);
                chk(dn == 0, "R4", dn, 0);
            end else if (w < last) begin
                s = (w - 6) % 22;
                e = exp_bit(s, h, k) ? PULSE : 0;
                if (s < 4)       chk(hi == e, "R5", hi, e);
                else if (s < 12) chk(hi == e, "R6", hi, e);
                else             chk(hi == e, "R7", hi, e);
                if (w == 6) chk(first == 3, "R8", first, 3);
                chk(dn == 0, "R9", dn, 0);
            end else begin
                chk(dn == 1, "R13", dn, 1);
                chk(st == 0, "R9", st, 0);
                chk(hi == 0, "R9", hi, 0);
            end
        end
        chk(ready == 1'b1, "R13", int'(ready), 1);
    endtask

    initial begin
        #(8 * 190000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R2", int'(ready), 1);
        chk(carrier == 1'b0, "R2", int'(carrier), 0);
        chk(done == 1'b0, "R13", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: out-of-range codes
        issue(16, 3, 2);
        chk(done == 1'b1 && status == 2'd1, "R1", int'(status), 1);
        @(negedge clk);
        chk(done == 1'b0 && ready == 1'b1, "R13", int'(done), 0);
        issue(2, 32, 2);
        chk(done == 1'b1 && status == 2'd1, "R1", int'(status), 1);
        for (int j = 0; j < 100; j++) begin
            @(negedge clk);
            if (j % 20 == 0) zc = ~zc;
            if (carrier) chk(1'b0, "R1", 1, 0);
        end

        // R10: zero repeats
        issue(1, 1, 0);
        chk(done == 1'b1 && status == 2'd0, "R10", int'(done), 1);
        @(negedge clk);
        chk(ready == 1'b1 && carrier == 1'b0, "R10", int'(carrier), 0);

        // R5..R8: sweep all keys, all houses
        for (int k = 0; k < 32; k++) run_cmd((k * 7) % 16, k, 1, 80);

        // R9 with minimum interval, R12 boundary with maximum interval
        run_cmd(9, 20, 2, 60);
        run_cmd(12, 5, 1, 85);

        // R11: interval one cycle under the minimum
        issue(4, 4, 1);
        repeat (4) @(negedge clk);
        zc = ~zc;
        repeat (59) @(negedge clk);
        zc = ~zc;
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && status == 2'd3, "R11", int'(status), 3);

        // R11: short interval in the middle of a burst
        issue(3, 5, 1);
        repeat (4) @(negedge clk);
        for (int w = 0; w < 6; w++) begin
            zc = ~zc;
            repeat (80) @(negedge clk);
        end
        zc = ~zc;
        repeat (8) @(negedge clk);
        chk(carrier == 1'b1, "R5", int'(carrier), 1);
        zc = ~zc;
        repeat (3) @(negedge clk);
        chk(carrier == 1'b0, "R11", int'(carrier), 0);
        chk(done == 1'b1 && status == 2'd3, "R11", int'(status), 3);

        // R12: crossings stop after slot 0 begins
        issue(6, 18, 1);
        repeat (4) @(negedge clk);
        for (int w = 0; w < 6; w++) begin
            zc = ~zc;
            repeat (80) @(negedge clk);
        end
        zc = ~zc;
        seen = 0;
        for (int j = 1; j <= 100; j++) begin
            @(negedge clk);
            if (done && seen == 0) begin
                seen = j;
                chk(status == 2'd3, "R12", int'(status), 3);
                chk(carrier == 1'b0, "R12", int'(carrier), 0);
            end
        end
        chk(seen == 89, "R12", seen, 89);

        // R3: no crossing at all
        issue(2, 2, 1);
        seen = 0;
        for (int j = 1; j <= TMOC + 100; j++) begin
            @(negedge clk);
            if (carrier) chk(1'b0, "R3", 1, 0);
            if (done && seen == 0) begin
                seen = j;
                chk(status == 2'd2, "R3", int'(status), 2);
            end
        end
        chk(seen == TMOC + 1, "R3", seen, TMOC + 1);
        chk(ready == 1'b1, "R13", int'(ready), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule